// File: doc/BRIEF.md
# Nibble-Serializing Display Port

This block is an output peripheral on a processor data bus that uses a strobe, a write enable and an acknowledge. It answers to four consecutive byte addresses. A write to any of them stores the byte and the low two address bits, which act as a digit select. The stored byte then leaves the chip over a narrow external bus that has a 4-bit data field, a 3-bit address field and an enable strobe. The low nibble goes first and the high nibble second. The nibble number is carried on the external address LSB.

Each nibble transfer drives address and data for two cycles with enable low. Enable is then high for one cycle, and a final hold cycle keeps address and data unchanged. This lets the external receiver latch both fields on the enable pulse without a race. A write that arrives while a transfer is running waits without an acknowledge until the port is idle again, so no byte is dropped. A read returns the byte captured most recently.

Top module: `nibble_disp_port`

## Requirements
- R1: The port responds only to bus addresses 0x40 to 0x43 (address bits [7:2] equal to 6'b010000). A strobe at any other address gets no acknowledge, starts no transfer and leaves the stored byte unchanged.
- R2: After reset and while idle, the external data, address and enable outputs are all zero, and the acknowledge is low.
- R3: A write (strobe=1, write enable=1, matching address) accepted at a clock edge while the port is idle raises the acknowledge in the next cycle. The same edge stores the byte and address bits [1:0].
- R4: In the first transfer cycle after acceptance, the external data carries byte bits [3:0] and the external address is {select[1:0], 1'b0}.
- R5: Before each enable pulse, address and data are driven for two consecutive cycles with enable low.
- R6: For each nibble, enable is high for exactly one cycle. The cycle after it has enable low with address and data unchanged.
- R7: Cycles 5 to 8 after acceptance repeat that pattern with byte bits [7:4] and address {select[1:0], 1'b1}. From cycle 9 the external bus is back at all zeros.
- R8: A write presented while a transfer is running is not acknowledged until the port has returned to idle. It is then accepted and sent in full.
- R9: A read (strobe=1, write enable=0, matching address) is acknowledged in the next cycle, even during a transfer. The read data equals the last stored byte and is zero when no read is acknowledged. The read does not disturb an ongoing transfer.
- R10: An acknowledge lasts one cycle. A strobe still high in the acknowledge cycle is not accepted again at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_adr_i | input | 8 | Processor bus address |
| bus_dat_i | input | 8 | Processor write data |
| bus_stb_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | Write enable (1 = write, 0 = read) |
| bus_dat_o | output | 8 | Read data, valid with a read acknowledge |
| bus_ack_o | output | 1 | Request acknowledge, one cycle |
| ext_dat_o | output | 4 | External nibble data |
| ext_adr_o | output | 3 | External address: {select, nibble number} |
| ext_en_o | output | 1 | External enable strobe |

## Verification
The assertions check on every cycle the properties that hold for any traffic:
- the enable pulse is one cycle wide;
- address and data are stable in the cycle before the pulse and the cycle after it;
- a transfer starts on the low nibble and ends on the last one;
- a single acknowledge is never stretched;
- a blocked write produces no acknowledge;
- the stored byte does not change during a transfer;
- an address outside the window is never acknowledged.

The exact cycle positions of the nine-cycle external sequence, the nibble values, and the read-back contents can only be shown by the bench scenarios. The same holds for the fact that a stalled write is sent intact, and for the point at which it is finally accepted.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/nsp_decode.sv
module nsp_decode #(
  parameter int ADR_W = 8,
  parameter int SEL_W = 2,
  parameter logic [ADR_W-1:0] BASE_ADR = 8'h40
) (
  input  logic [ADR_W-1:0] adr_i,
  output logic             hit_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int TAG_W = ADR_W - SEL_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADR[ADR_W-1:SEL_W];

  assign hit_o = (adr_i[ADR_W-1:SEL_W] == BASE_TAG);
  assign sel_o = adr_i[SEL_W-1:0];
endmodule

// File: rtl/nsp_bus_if.sv
module nsp_bus_if #(
  parameter int DAT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic             busy_i,
  output logic             ack_o,
  output logic [DAT_W-1:0] dat_o,
  output logic             start_o,
  output logic [DAT_W-1:0] word_o,
  output logic [SEL_W-1:0] sel_o
);
  logic             ack_q, rd_q;
  logic [DAT_W-1:0] word_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_take, rd_take;

  // ack_q gate keeps a strobe held through the ack cycle from re-firing
  assign wr_take = hit_i && stb_i &&  we_i && !busy_i && !ack_q;
  assign rd_take = hit_i && stb_i && !we_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      word_q <= '0;
      sel_q  <= '0;
    end else begin
      ack_q <= wr_take || rd_take;
      rd_q  <= rd_take;
      if (wr_take) begin
        word_q <= dat_i;
        sel_q  <= sel_i;
      end
    end
  end

  assign ack_o   = ack_q;
  assign dat_o   = rd_q ? word_q : '0;
  assign start_o = wr_take;
  assign word_o  = word_q;
  assign sel_o   = sel_q;

  p_ack_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  p_no_wr_ack_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && we_i && busy_i) |=> !(ack_q && !rd_q));

  p_word_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(word_q) && $stable(sel_q)));
endmodule

// File: rtl/nsp_seq.sv
module nsp_seq
  import nsp_pkg::*;
#(
  parameter int DAT_W     = 8,
  parameter int NIB_W     = 4,
  parameter int SEL_W     = 2,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 1,
  localparam int NIBS     = DAT_W / NIB_W,
  localparam int IDX_W    = (NIBS > 1) ? $clog2(NIBS) : 1,
  localparam int EXT_AW   = SEL_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DAT_W-1:0]  word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              busy_o,
  output logic [NIB_W-1:0]  ext_dat_o,
  output logic [EXT_AW-1:0] ext_adr_o,
  output logic              ext_en_o
);
  localparam int CNT_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_st_e          state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NIB_W-1:0] nib_a [NIBS];

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib_a[g] = word_i[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          idx_q   <= '0;
          cnt_q   <= '0;
        end
        ST_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
            state_q <= ST_STROBE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STROBE: begin
          state_q <= ST_HOLD;
          cnt_q   <= '0;
        end
        ST_HOLD: begin
          if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
            cnt_q <= '0;
            if (idx_q == IDX_W'(NIBS - 1)) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else begin
              state_q <= ST_SETUP;
              idx_q   <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign ext_en_o  = (state_q == ST_STROBE);
  assign ext_dat_o = busy_o ? nib_a[idx_q] : '0;
  assign ext_adr_o = busy_o ? {sel_i, idx_q} : '0;

  p_en_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_en_o |=> !ext_en_o);

  p_setup_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_en_o |-> ($stable(ext_adr_o) && $stable(ext_dat_o) && !$past(ext_en_o)));

  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_en_o |=> ($stable(ext_adr_o) && $stable(ext_dat_o)));

  p_low_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ext_adr_o[IDX_W-1:0] == '0));

  p_high_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(ext_adr_o[IDX_W-1:0]) == IDX_W'(NIBS - 1)));
endmodule

// File: rtl/nibble_disp_port.sv
module nibble_disp_port #(
  parameter int ADR_W                = 8,
  parameter int DAT_W                = 8,
  parameter int NIB_W                = 4,
  parameter int SEL_W                = 2,
  parameter logic [ADR_W-1:0] BASE_ADR = 8'h40,
  parameter int SETUP_CYC            = 2,
  parameter int HOLD_CYC             = 1,
  localparam int NIBS                = DAT_W / NIB_W,
  localparam int IDX_W               = (NIBS > 1) ? $clog2(NIBS) : 1,
  localparam int EXT_AW              = SEL_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  bus_adr_i,
  input  logic [DAT_W-1:0]  bus_dat_i,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  output logic [DAT_W-1:0]  bus_dat_o,
  output logic              bus_ack_o,
  output logic [NIB_W-1:0]  ext_dat_o,
  output logic [EXT_AW-1:0] ext_adr_o,
  output logic              ext_en_o
);
  logic             hit, start, busy;
  logic [SEL_W-1:0] sel_in, sel_q;
  logic [DAT_W-1:0] word_q;

  nsp_decode #(.ADR_W(ADR_W), .SEL_W(SEL_W), .BASE_ADR(BASE_ADR)) u_dec (
    .adr_i(bus_adr_i), .hit_o(hit), .sel_o(sel_in)
  );

  nsp_bus_if #(.DAT_W(DAT_W), .SEL_W(SEL_W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .sel_i(sel_in),
    .stb_i(bus_stb_i), .we_i(bus_we_i), .dat_i(bus_dat_i), .busy_i(busy),
    .ack_o(bus_ack_o), .dat_o(bus_dat_o), .start_o(start),
    .word_o(word_q), .sel_o(sel_q)
  );

  nsp_seq #(.DAT_W(DAT_W), .NIB_W(NIB_W), .SEL_W(SEL_W),
            .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .word_i(word_q),
    .sel_i(sel_q), .busy_o(busy), .ext_dat_o(ext_dat_o),
    .ext_adr_o(ext_adr_o), .ext_en_o(ext_en_o)
  );

  p_outside_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_i && (bus_adr_i[ADR_W-1:SEL_W] != BASE_ADR[ADR_W-1:SEL_W])) |=> !bus_ack_o);
endmodule

// File: tb/sim_nibble_disp_port.sv
`timescale 1ns/1ps
module sim_nibble_disp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] adr = '0, wdat = '0;
  logic       stb = 1'b0, we = 1'b0;
  logic [7:0] rdat;
  logic       ack;
  logic [3:0] xdat;
  logic [2:0] xadr;
  logic       xen;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] last_word = '0;

  always #2.5 clk = ~clk;

  nibble_disp_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_adr_i(adr), .bus_dat_i(wdat),
    .bus_stb_i(stb), .bus_we_i(we), .bus_dat_o(rdat), .bus_ack_o(ack),
    .ext_dat_o(xdat), .ext_adr_o(xadr), .ext_en_o(xen)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {en, adr[2:0], dat[3:0]} in cycle k after acceptance
  function automatic int exp_ext(int k, logic [1:0] sel, logic [7:0] d);
    int nib, pos;
    if (k < 1 || k > 8) return 0;
    nib = (k - 1) / 4;
    pos = (k - 1) % 4;
    return ((pos == 2) ? 128 : 0) + ({sel, 1'(nib)} * 16) +
           int'(nib == 1 ? d[7:4] : d[3:0]);
  endfunction

  function automatic int ext_now();
    return int'({xen, xadr, xdat});
  endfunction

  function automatic string lbl(int k);
    int nib, pos;
    if (k > 8) return "R7 idle";
    nib = (k - 1) / 4;
    pos = (k - 1) % 4;
    return $sformatf("%s %s k=%0d", nib == 1 ? "R7" : "R4", pos < 2 ? "R5" : "R6", k);
  endfunction

  // called at negedge of cycle 1 after acceptance; ends at negedge of cycle 9
  task automatic check_seq(input logic [1:0] sel, input logic [7:0] d);
    for (int k = 1; k <= 9; k++) begin
      chk(lbl(k), ext_now(), exp_ext(k, sel, d));
      if (k < 9) @(negedge clk);
    end
  endtask

  // R3: write issued in idle; ack expected in first cycle
  task automatic wr_idle(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    adr = a; wdat = d; stb = 1'b1; we = 1'b1;
    @(negedge clk);
    chk("R3 ack", int'(ack), 1);
    stb = 1'b0; we = 1'b0;
    last_word = d;
    check_seq(a[1:0], d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    adr = a; stb = 1'b1; we = 1'b0;
    @(negedge clk);
    chk("R9 read ack", int'(ack), 1);
    chk("R9 read data", int'(rdat), int'(exp));
    stb = 1'b0;
    @(negedge clk);
    chk("R9 data zero after", int'(rdat), 0);
  endtask

  task automatic wr_outside(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    adr = a; wdat = d; stb = 1'b1; we = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 no ack", int'(ack), 0);
      chk("R1 bus quiet", ext_now(), 0);
    end
    stb = 1'b0; we = 1'b0;
  endtask

  initial begin
    logic [7:0] a, d, d2;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R2 reset ack", int'(ack), 0);
    chk("R2 reset bus", ext_now(), 0);
    chk("R2 reset rdata", int'(rdat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle bus", ext_now(), 0);

    // directed nibble patterns on each select
    wr_idle(8'h40, 8'h3C);
    wr_idle(8'h41, 8'hA5);
    wr_idle(8'h42, 8'hF0);
    wr_idle(8'h43, 8'h0F);
    rd(8'h41, 8'h0F);

    // R1 window boundaries
    wr_outside(8'h44, 8'h77);
    wr_outside(8'h3F, 8'h66);
    wr_outside(8'hC0, 8'h55);
    rd(8'h40, last_word);

    // R8: second write stalled behind a running transfer
    d = 8'h96; d2 = 8'h2B;
    @(negedge clk);
    adr = 8'h42; wdat = d; stb = 1'b1; we = 1'b1;
    @(negedge clk);
    chk("R3 ack", int'(ack), 1);
    adr = 8'h41; wdat = d2;
    for (int k = 1; k <= 9; k++) begin
      chk(lbl(k), ext_now(), exp_ext(k, 2'd2, d));
      if (k > 1) chk("R8 stalled no ack", int'(ack), 0);
      @(negedge clk);
    end
    chk("R8 ack after idle", int'(ack), 1);
    stb = 1'b0; we = 1'b0;
    last_word = d2;
    check_seq(2'd1, d2);
    rd(8'h43, d2);

    // R9: read during a transfer leaves it intact
    d = 8'hD4;
    @(negedge clk);
    adr = 8'h43; wdat = d; stb = 1'b1; we = 1'b1;
    @(negedge clk);
    chk("R3 ack", int'(ack), 1);
    stb = 1'b0; we = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      chk(lbl(k), ext_now(), exp_ext(k, 2'd3, d));
      if (k == 2) begin adr = 8'h40; stb = 1'b1; we = 1'b0; end
      if (k == 3) begin
        chk("R9 busy read ack", int'(ack), 1);
        chk("R9 busy read data", int'(rdat), int'(d));
        stb = 1'b0;
      end
      if (k < 9) @(negedge clk);
    end
    last_word = d;

    // R10: read strobe held through the ack cycle
    @(negedge clk);
    adr = 8'h42; stb = 1'b1; we = 1'b0;
    @(negedge clk);
    chk("R10 first ack", int'(ack), 1);
    @(negedge clk);
    chk("R10 no back-to-back ack", int'(ack), 0);
    stb = 1'b0;
    @(negedge clk);

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      a = 8'h40 + 8'($urandom_range(0, 3));
      d = 8'($urandom);
      if (op <= 2) wr_idle(a, d);
      else if (op <= 4) rd(a, last_word);
      else begin
        a = 8'($urandom);
        if (a[7:2] == 6'b010000) a = 8'h80;
        wr_outside(a, d);
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    rd(8'h40, last_word);

    finish_run();
  end
endmodule